// File: doc/BRIEF.md
# Digest Context Register Bank

This block keeps the running state of a SHA-2 engine as sixteen 32-bit words that software can reach over a simple register bus. While the engine is running, only the engine's update port can change the words. It loads the whole digest at once when a compression step completes.

While the engine is stopped, software may write any word. A context saved earlier can therefore be put back, and several message streams can share one engine. Dropping the engine enable wipes the stored digest. A sticky done flag tells software that a final digest is ready.

Reads return one word, one cycle after the request. The digest-size selector decides which words carry a result. A word beyond the selected size reads as zero. The raw stored value on `digest_out` is never masked. Address 16 is a control word: bit 0 reads back the done flag, and writing 1 to bit 0 clears it.

Top module: `digest_ctx_bank`

## Requirements
- R1: After reset every digest word is 0x0, `done_irq` is 0 and `rd_data` is 0.
- R2: A bus write to word address 0..15 while `eng_en` is 0 stores `wr_data` in that word from the next cycle.
- R3: A bus write to word address 0..15 while `eng_en` is 1 is ignored, and the word keeps its value.
- R4: While `eng_en` is 1, `upd_valid` loads all sixteen words from `upd_digest` in one cycle. Word 0 takes bits [511:480] and word 15 takes bits [31:0]. `digest_out` uses the same ordering, {W0, W1, ..., W15}.
- R5: In the cycle after `eng_en` goes from 1 to 0, every word is zero. A bus write presented in that same cycle is discarded.
- R6: `rd_data` shows the addressed word one cycle after `rd_en`, and holds its value in cycles without `rd_en`.
- R7: `size_sel` is decoded as 0 = 256-bit (words 0..7), 1 = 384-bit (words 0..11), and 2 or 3 = 512-bit (words 0..15). A read of a word outside the selected size returns zero. A read of an address above 16 also returns zero. `digest_out` is not masked.
- R8: `done_strobe` sets `done_irq` from the next cycle, and the flag stays set until it is cleared.
- R9: A bus write to address 16 with bit 0 set clears `done_irq`. If `done_strobe` is high in the same cycle, the set wins. A read of address 16 returns `done_irq` in bit 0 and zero in all other bits.
- R10: `upd_valid` has no effect while `eng_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_en | input | 1 | Engine enable; a falling edge clears the digest |
| size_sel | input | 2 | Digest size: 0 = 256, 1 = 384, 2/3 = 512 |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 5 | Write word address (0..15 digest, 16 control) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| upd_valid | input | 1 | Engine loads a whole digest |
| upd_digest | input | 512 | Digest from the engine, word 0 in the MSBs |
| done_strobe | input | 1 | Final digest available |
| digest_out | output | 512 | Stored words {W0..W15}, unmasked |
| done_irq | output | 1 | Sticky done flag |

## Verification
Every result is due one clock edge after its stimulus. This covers a write landing in a word, an update load, the clear that follows an enable fall, a flag set or clear, and `rd_data` after a read request.

Inputs change at the falling clock edge. The bench then updates its reference model at the next rising edge, using the pre-edge state for reads. It compares at the following falling edge, so each comparison sees exactly one register stage of delay. Directed cases cover the overlaps: a write in the same cycle as an enable fall, a set and a clear together, masked reads at each size boundary, and updates while disabled.

// File: rtl/digest_ctx_bank.sv
`timescale 1ns/1ps
module digest_ctx_bank #(
  parameter int WORDS = 16,
  parameter int DW = 32,
  localparam int AW = $clog2(WORDS) + 1,
  localparam int IW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eng_en,
  input  logic [1:0]          size_sel,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic                upd_valid,
  input  logic [WORDS*DW-1:0] upd_digest,
  input  logic                done_strobe,
  output logic [WORDS*DW-1:0] digest_out,
  output logic                done_irq
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(WORDS);
  localparam logic [AW-1:0] LIM_S = AW'(WORDS / 2);
  localparam logic [AW-1:0] LIM_M = AW'((WORDS * 3) / 4);
  localparam logic [AW-1:0] LIM_L = AW'(WORDS);

  logic [DW-1:0] word_q [WORDS];
  logic          en_q;
  logic [DW-1:0] rd_next;
  logic [AW-1:0] lim;

  wire wipe    = en_q & ~eng_en;
  wire load    = eng_en & upd_valid;
  wire sw_ok   = ~eng_en & wr_en;
  wire ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= eng_en;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           word_q[i] <= '0;
      else if (wipe)                        word_q[i] <= '0;
      else if (load)                        word_q[i] <= upd_digest[(WORDS-1-i)*DW +: DW];
      else if (sw_ok && wr_addr == AW'(i))  word_q[i] <= wr_data;
    assign digest_out[(WORDS-1-i)*DW +: DW] = word_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         done_irq <= 1'b0;
    else if (done_strobe)               done_irq <= 1'b1;
    else if (ctrl_wr && wr_data[0])     done_irq <= 1'b0;

  assign lim = (size_sel == 2'd0) ? LIM_S : (size_sel == 2'd1) ? LIM_M : LIM_L;

  always_comb begin
    rd_next = '0;
    if (rd_addr == CTRL_ADDR) rd_next = {{(DW-1){1'b0}}, done_irq};
    else if (rd_addr < lim)   rd_next = word_q[rd_addr[IW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;

  AST_WIPE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_en) |=> (digest_out == '0)); // R5
  AST_LOCKED_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && !upd_valid) |=> $stable(digest_out)); // R3
  AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && upd_valid) |=> (digest_out == $past(upd_digest))); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R6
  AST_RD_MASK_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size_sel == 2'd0 && rd_addr >= LIM_S && rd_addr < CTRL_ADDR) |=> (rd_data == '0)); // R7
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done_strobe |=> done_irq); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR && wr_data[0] && !done_strobe) |=> !done_irq); // R9
endmodule

// File: tb/sim_digest_ctx_bank.sv
`timescale 1ns/1ps
module sim_digest_ctx_bank;
  logic clk = 0, rst_n = 0;
  logic eng_en = 0, wr_en = 0, rd_en = 0, upd_valid = 0, done_strobe = 0;
  logic [1:0] size_sel = 2;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [511:0] upd_digest = 0, digest_out;
  logic done_irq;

  always #2 clk = ~clk;

  digest_ctx_bank u0 (.clk(clk), .rst_n(rst_n), .eng_en(eng_en), .size_sel(size_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .upd_valid(upd_valid), .upd_digest(upd_digest),
    .done_strobe(done_strobe), .digest_out(digest_out), .done_irq(done_irq));

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [31:0] m [16];
  logic m_irq = 0, m_prev = 0;
  logic [31:0] m_rd = 0;

  function automatic logic [31:0] mread(logic [4:0] a, logic [1:0] s);
    int lim;
    lim = (s == 0) ? 8 : (s == 1) ? 12 : 16;
    if (a == 16) return {31'b0, m_irq};
    if (int'(a) < lim) return m[a[3:0]];
    return 32'h0;
  endfunction

  function automatic logic [511:0] mpack();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[(15-i)*32 +: 32] = m[i];
    return v;
  endfunction

  task automatic model();
    logic fall;
    fall = m_prev & ~eng_en;
    if (rd_en) m_rd = mread(rd_addr, size_sel);
    if (fall) for (int i = 0; i < 16; i++) m[i] = 0;
    else if (eng_en && upd_valid) for (int i = 0; i < 16; i++) m[i] = upd_digest[(15-i)*32 +: 32];
    else if (!eng_en && wr_en && wr_addr < 16) m[wr_addr[3:0]] = wr_data;
    if (done_strobe) m_irq = 1;
    else if (wr_en && wr_addr == 16 && wr_data[0]) m_irq = 0;
    m_prev = eng_en;
  endtask

  task automatic step();
    @(posedge clk); model(); @(negedge clk);
    wr_en = 0; rd_en = 0; upd_valid = 0; done_strobe = 0;
  endtask

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd(logic [4:0] a);
    rd_en = 1; rd_addr = a; step();
  endtask

  logic [511:0] pat;

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 digest", digest_out, 512'h0);
    chk("R1 irq", {511'b0, done_irq}, 512'h0);
    chk("R1 rd_data", {480'b0, rd_data}, 512'h0);

    wr(5'd3, 32'hA5A5_0003);
    chk("R2 word3 stored", digest_out[(15-3)*32 +: 32], 512'hA5A5_0003);
    rd(5'd3);
    chk("R6 read word3", {480'b0, rd_data}, 512'hA5A5_0003);
    chk("R6 hold", {480'b0, rd_data}, {480'b0, m_rd});
    rd_addr = 5'd0; step();
    chk("R6 no rd_en holds", {480'b0, rd_data}, 512'hA5A5_0003);

    wr(5'd9, 32'h0000_0909);
    wr(5'd11, 32'h0000_0B0B);
    wr(5'd12, 32'h0000_0C0C);
    size_sel = 0; rd(5'd9);
    chk("R7 256 masks word9", {480'b0, rd_data}, 512'h0);
    chk("R7 digest_out unmasked", digest_out[(15-9)*32 +: 32], 512'h0909);
    size_sel = 1; rd(5'd11);
    chk("R7 384 word11", {480'b0, rd_data}, 512'h0B0B);
    rd(5'd12);
    chk("R7 384 masks word12", {480'b0, rd_data}, 512'h0);
    size_sel = 3; rd(5'd12);
    chk("R7 sel3 word12", {480'b0, rd_data}, 512'h0C0C);
    rd(5'd20);
    chk("R7 high address", {480'b0, rd_data}, 512'h0);
    size_sel = 2;

    eng_en = 1; step();
    wr(5'd3, 32'h0);
    chk("R3 write ignored when enabled", digest_out, mpack());
    chk("R3 word3 kept", digest_out[(15-3)*32 +: 32], 512'hA5A5_0003);

    for (int i = 0; i < 16; i++) pat[(15-i)*32 +: 32] = 32'h1000_0000 + i;
    upd_valid = 1; upd_digest = pat; step();
    chk("R4 update load", digest_out, pat);
    rd(5'd0);
    chk("R4 word0 is MSBs", {480'b0, rd_data}, 512'h1000_0000);

    eng_en = 0; wr(5'd5, 32'hDEAD_BEEF);
    chk("R5 wipe beats write", digest_out, 512'h0);
    upd_valid = 1; upd_digest = pat; step();
    chk("R10 update ignored when disabled", digest_out, 512'h0);

    done_strobe = 1; step();
    chk("R8 set", {511'b0, done_irq}, 512'h1);
    step();
    chk("R8 sticky", {511'b0, done_irq}, 512'h1);
    wr(5'd16, 32'h1);
    chk("R9 clear", {511'b0, done_irq}, 512'h0);
    done_strobe = 1; wr(5'd16, 32'h1);
    chk("R9 set wins", {511'b0, done_irq}, 512'h1);
    rd(5'd16);
    chk("R9 read flag", {480'b0, rd_data}, 512'h1);

    for (int n = 0; n < 600; n++) begin
      if ($urandom % 8 == 0) eng_en = ~eng_en;
      size_sel = 2'($urandom);
      wr_en = ($urandom % 2) == 0; wr_addr = 5'($urandom % 20); wr_data = $urandom;
      if (wr_addr == 16 && ($urandom % 2) == 0) wr_data[0] = 1'b0;
      rd_en = ($urandom % 2) == 0; rd_addr = 5'($urandom % 20);
      upd_valid = ($urandom % 6) == 0;
      for (int i = 0; i < 16; i++) upd_digest[i*32 +: 32] = $urandom;
      done_strobe = ($urandom % 8) == 0;
      step();
      chk("R2 R3 R4 R5 R10 random digest", digest_out, mpack());
      chk("R6 R7 R9 random read", {480'b0, rd_data}, {480'b0, m_rd});
      chk("R8 R9 random flag", {511'b0, done_irq}, {511'b0, m_irq});
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule